// File: doc/BRIEF.md
# Ring Diagnostic Monitor

This block sits beside the token-passing engine of a ring network node and watches every token that goes past, whatever node it is meant for. The host programs a probe ID. When a token's destination ID equals that probe ID, a reply window opens. If the addressed node then answers before the next token appears, a sticky "probe answered" flag is set. By sweeping the probe ID while the node stays on the ring, software can find out which stations are present.

The block also holds the node's successor ID. Each time the ring logic writes a new successor, the value is stored and a "successor changed" flag is raised, because a station has joined or left the ring. A read of the diagnostic status does not clear this flag. A read of the successor register does. The flag drives an interrupt line, and a host mask bit gates that line.

Top module: `ring_diag_monitor`

## Requirements
- R1: After reset, and whenever reset is applied, `probe_hit_o`, `succ_new_o`, `irq_o` and `succ_id_o` are all zero, and the probe ID register and reply window are cleared.
- R2: A token whose destination ID equals the stored probe ID opens the reply window. A response strobe that arrives while the window is open sets `probe_hit_o` on the next clock edge. The flag then stays set.
- R3: A response strobe has no effect on `probe_hit_o` when no window is open. This covers the case where no token has been seen yet and the case where the last token did not match.
- R4: The window stays open over idle cycles until the next token. Any later token replaces the window with that token's own match result. Tokens for any destination ID are compared.
- R5: A host write of the probe ID clears `probe_hit_o` and closes the window. The write takes priority over a response in the same cycle. Tokens that follow the write are compared against the new ID.
- R6: A successor update strobe loads `succ_val_i` into `succ_id_o` and sets `succ_new_o` on the next clock edge.
- R7: A status read (`stat_rd_i`) leaves `succ_new_o` unchanged.
- R8: A successor read (`succ_rd_i`) clears `succ_new_o` on the next clock edge.
- R9: If a successor update and a successor read occur in the same cycle, the update wins. `succ_new_o` stays or becomes 1, and the new value is loaded.
- R10: `irq_o` is 1 only while `succ_new_o` is 1 and `irq_en_i` is 1. It follows `irq_en_i` combinationally.
- R11: If a token and a response occur in the same cycle, the response is judged against the window that was open before that token. The token then sets the window for the cycles that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token observed this cycle |
| tok_dest_i | input | ID_W | First destination ID of the observed token |
| resp_valid_i | input | 1 | Response from the addressed node observed |
| probe_wr_i | input | 1 | Host write of the probe ID |
| probe_id_i | input | ID_W | Probe ID write data |
| succ_upd_i | input | 1 | Successor ID update strobe |
| succ_val_i | input | ID_W | New successor ID |
| stat_rd_i | input | 1 | Host read of the diagnostic status |
| succ_rd_i | input | 1 | Host read of the successor ID |
| irq_en_i | input | 1 | Interrupt mask for the successor-changed flag |
| probe_hit_o | output | 1 | Probe answered flag |
| succ_new_o | output | 1 | Successor changed flag |
| succ_id_o | output | ID_W | Successor ID register |
| irq_o | output | 1 | Interrupt request |

## Verification
There are two pairs of events that can land on the same edge, and each is driven together in one vector. The first pair is a successor update and a successor read. Here the flag must stay set and the new value must appear, not the flag clearing. The second pair is a token and a response in one cycle. A response that follows a non-matching token must not score, even when the new token itself matches. A response on the cycle of the next token must still score against the window left by the earlier matching token. A probe-ID write made alongside an open window is also checked, to confirm that the write closes the window.

// File: rtl/ring_diag_pkg.sv
package ring_diag_pkg;
  localparam int unsigned DEF_ID_W = 8;

  function automatic logic id_eq(input logic [31:0] a, input logic [31:0] b);
    return a == b;
  endfunction
endpackage

// File: rtl/probe_tracker.sv
module probe_tracker
  import ring_diag_pkg::*;
#(
  parameter int unsigned ID_W = DEF_ID_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tok_valid_i,
  input  logic [ID_W-1:0] tok_dest_i,
  input  logic            resp_valid_i,
  input  logic            probe_wr_i,
  input  logic [ID_W-1:0] probe_id_i,
  output logic            hit_o
);
  localparam int unsigned PadW = 32 - ID_W;

  logic [ID_W-1:0] probe_q;
  logic            win_q;
  logic            hit_q;
  logic            tok_match;

  assign tok_match = id_eq({{PadW{1'b0}}, tok_dest_i}, {{PadW{1'b0}}, probe_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      probe_q <= '0;
      win_q   <= 1'b0;
      hit_q   <= 1'b0;
    end else if (probe_wr_i) begin
      probe_q <= probe_id_i;
      win_q   <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      // response is scored against the window left by the previous token
      if (win_q && resp_valid_i) hit_q <= 1'b1;
      if (tok_valid_i)           win_q <= tok_match;
    end
  end

  assign hit_o = hit_q;

  // R2
  property hit_set_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (win_q && resp_valid_i && !probe_wr_i) |=> hit_q;
  endproperty
  hit_set_chk: assert property (hit_set_p);

  // R3
  property no_spurious_hit_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (!hit_q && !win_q) |=> !hit_q;
  endproperty
  no_spurious_hit_chk: assert property (no_spurious_hit_p);

  // R5
  property wr_clear_p;
    @(posedge clk_i) disable iff (!rst_ni)
      probe_wr_i |=> (!hit_q && !win_q && probe_q == $past(probe_id_i));
  endproperty
  wr_clear_chk: assert property (wr_clear_p);

  // R4
  property win_hold_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (!tok_valid_i && !probe_wr_i) |=> $stable(win_q);
  endproperty
  win_hold_chk: assert property (win_hold_p);
endmodule

// File: rtl/succ_tracker.sv
module succ_tracker
  import ring_diag_pkg::*;
#(
  parameter int unsigned ID_W = DEF_ID_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [ID_W-1:0] val_i,
  input  logic            stat_rd_i,
  input  logic            rd_i,
  output logic            new_o,
  output logic [ID_W-1:0] id_o
);
  logic [ID_W-1:0] id_q;
  logic            new_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= '0;
      new_q <= 1'b0;
    end else begin
      if (upd_i) id_q <= val_i;
      // update outranks a same-cycle clearing read
      if (upd_i)     new_q <= 1'b1;
      else if (rd_i) new_q <= 1'b0;
    end
  end

  assign new_o = new_q;
  assign id_o  = id_q;

  // R6 R9
  property upd_load_p;
    @(posedge clk_i) disable iff (!rst_ni)
      upd_i |=> (new_q && id_q == $past(val_i));
  endproperty
  upd_load_chk: assert property (upd_load_p);

  // R7
  property stat_rd_keep_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (new_q && stat_rd_i && !rd_i) |=> new_q;
  endproperty
  stat_rd_keep_chk: assert property (stat_rd_keep_p);

  // R8
  property rd_clear_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !upd_i) |=> !new_q;
  endproperty
  rd_clear_chk: assert property (rd_clear_p);
endmodule

// File: rtl/ring_diag_monitor.sv
module ring_diag_monitor
  import ring_diag_pkg::*;
#(
  parameter int unsigned ID_W = DEF_ID_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tok_valid_i,
  input  logic [ID_W-1:0] tok_dest_i,
  input  logic            resp_valid_i,
  input  logic            probe_wr_i,
  input  logic [ID_W-1:0] probe_id_i,
  input  logic            succ_upd_i,
  input  logic [ID_W-1:0] succ_val_i,
  input  logic            stat_rd_i,
  input  logic            succ_rd_i,
  input  logic            irq_en_i,
  output logic            probe_hit_o,
  output logic            succ_new_o,
  output logic [ID_W-1:0] succ_id_o,
  output logic            irq_o
);
  probe_tracker #(.ID_W(ID_W)) u_probe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tok_valid_i  (tok_valid_i),
    .tok_dest_i   (tok_dest_i),
    .resp_valid_i (resp_valid_i),
    .probe_wr_i   (probe_wr_i),
    .probe_id_i   (probe_id_i),
    .hit_o        (probe_hit_o)
  );

  succ_tracker #(.ID_W(ID_W)) u_succ (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (succ_upd_i),
    .val_i     (succ_val_i),
    .stat_rd_i (stat_rd_i),
    .rd_i      (succ_rd_i),
    .new_o     (succ_new_o),
    .id_o      (succ_id_o)
  );

  assign irq_o = succ_new_o & irq_en_i;

  // R10
  property irq_masked_p;
    @(posedge clk_i) disable iff (!rst_ni)
      !irq_en_i |-> !irq_o;
  endproperty
  irq_masked_chk: assert property (irq_masked_p);

  // R10
  property irq_src_p;
    @(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> succ_new_o;
  endproperty
  irq_src_chk: assert property (irq_src_p);
endmodule

// File: tb/ring_diag_monitor_tb.sv
module ring_diag_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 8;
  localparam int N_VEC = 18;

  typedef struct packed {
    logic            tok;
    logic [ID_W-1:0] dest;
    logic            resp;
    logic            wr;
    logic [ID_W-1:0] pid;
    logic            upd;
    logic [ID_W-1:0] sval;
    logic            srd;
    logic            nrd;
    logic            en;
    logic            e_hit;
    logic            e_new;
    logic [ID_W-1:0] e_sid;
    logic            e_irq;
    logic [7:0]      req;
  } vec_t;

  // tok dest resp wr pid upd sval srd nrd en | hit new sid irq req
  localparam vec_t VEC [N_VEC] = '{
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h5a, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd5},  // R5 load probe
    '{1'b1, 8'h5a, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd2},  // R2 arm
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd4},  // R4 idle keeps window
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd2},  // R2 answer
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd2},  // R2 sticky
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd5},  // R5 write beats resp
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd5},  // R5 window closed
    '{1'b1, 8'h12, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd3},  // R3 other dest
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd3},  // R3 no score
    '{1'b1, 8'h33, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'd11}, // R11 old window shut
    '{1'b1, 8'h77, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd11}, // R11 old window open
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'd4},  // R4 closed, hit holds
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h44, 1'b0, 8'd6},  // R6 masked
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 1'b1, 8'd10}, // R10 unmask
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 1'b1, 8'd7},  // R7 status read
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h44, 1'b0, 8'd8},  // R8 succ read
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h09, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h09, 1'b1, 8'd9},  // R9 upd beats read
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h09, 1'b0, 8'd8}   // R8 clear
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tok_valid_i = 1'b0;
  logic [ID_W-1:0] tok_dest_i = '0;
  logic            resp_valid_i = 1'b0;
  logic            probe_wr_i = 1'b0;
  logic [ID_W-1:0] probe_id_i = '0;
  logic            succ_upd_i = 1'b0;
  logic [ID_W-1:0] succ_val_i = '0;
  logic            stat_rd_i = 1'b0;
  logic            succ_rd_i = 1'b0;
  logic            irq_en_i = 1'b0;
  logic            probe_hit_o;
  logic            succ_new_o;
  logic [ID_W-1:0] succ_id_o;
  logic            irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ring_diag_monitor #(.ID_W(ID_W)) u_dut (.*);

  task automatic chk(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    tok_valid_i = 1'b0; resp_valid_i = 1'b0; probe_wr_i = 1'b0;
    succ_upd_i = 1'b0; stat_rd_i = 1'b0; succ_rd_i = 1'b0;
  endtask

  task automatic check_zero(input int req);
    chk("hit", req, {7'd0, probe_hit_o}, 8'd0);
    chk("new", req, {7'd0, succ_new_o}, 8'd0);
    chk("sid", req, succ_id_o, 8'd0);
    chk("irq", req, {7'd0, irq_o}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check_zero(1); // R1 in reset
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_zero(1); // R1 after release

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk_i);
      tok_valid_i = VEC[i].tok;   tok_dest_i = VEC[i].dest;
      resp_valid_i = VEC[i].resp; probe_wr_i = VEC[i].wr;
      probe_id_i = VEC[i].pid;    succ_upd_i = VEC[i].upd;
      succ_val_i = VEC[i].sval;   stat_rd_i = VEC[i].srd;
      succ_rd_i = VEC[i].nrd;     irq_en_i = VEC[i].en;
      @(posedge clk_i); #1;
      chk($sformatf("v%0d hit", i), int'(VEC[i].req), {7'd0, probe_hit_o}, {7'd0, VEC[i].e_hit});
      chk($sformatf("v%0d new", i), int'(VEC[i].req), {7'd0, succ_new_o}, {7'd0, VEC[i].e_new});
      chk($sformatf("v%0d sid", i), int'(VEC[i].req), succ_id_o, VEC[i].e_sid);
      chk($sformatf("v%0d irq", i), int'(VEC[i].req), {7'd0, irq_o}, {7'd0, VEC[i].e_irq});
    end

    // R10 irq follows mask combinationally
    @(negedge clk_i);
    drive_idle();
    succ_upd_i = 1'b1; succ_val_i = 8'h61; irq_en_i = 1'b0;
    @(posedge clk_i); #1;
    drive_idle();
    chk("irq masked", 10, {7'd0, irq_o}, 8'd0);
    irq_en_i = 1'b1; #1;
    chk("irq unmasked", 10, {7'd0, irq_o}, 8'd1);

    // R4 window spans many idle cycles after probe 0x21 token
    @(negedge clk_i);
    probe_wr_i = 1'b1; probe_id_i = 8'h21;
    @(negedge clk_i);
    drive_idle(); tok_valid_i = 1'b1; tok_dest_i = 8'h21;
    @(negedge clk_i);
    drive_idle();
    repeat (6) @(negedge clk_i);
    chk("hit before resp", 4, {7'd0, probe_hit_o}, 8'd0);
    resp_valid_i = 1'b1;
    @(posedge clk_i); #1;
    drive_idle();
    chk("hit after long window", 4, {7'd0, probe_hit_o}, 8'd1);

    // R1 reset mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    check_zero(1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 probe register cleared: a token to ID 0 must arm
    tok_valid_i = 1'b1; tok_dest_i = 8'h00;
    @(negedge clk_i);
    drive_idle(); resp_valid_i = 1'b1;
    @(posedge clk_i); #1;
    drive_idle();
    chk("probe reg zero after reset", 1, {7'd0, probe_hit_o}, 8'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule